// File: doc/BRIEF.md
# Configurable-Format Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. The host reaches four byte-wide registers through a small write port. One is a format register that sets the character width, the parity scheme, the stop length and a forced-low line mode. Another is a transmit holding byte. The last two are the low and high halves of a 16-bit baud divisor. The divisor halves share their select codes with the holding byte and an unused enable slot, and a bit of the format register steers those writes.

An internal tick runs at sixteen times the bit rate. It comes from dividing the clock by the divisor. A shift engine takes the holding byte as soon as it is free, copies the active format into the frame, and sends the frame. If the host has already refilled the holding byte, the next frame starts right after the last stop tick with no idle gap between frames. Two status outputs show whether the holding byte is empty and whether the whole transmitter is empty.

Top module: `serial_tx_framer`

## Requirements
- R1: While reset is held and on the first cycle after it, `txd` is 1, `hold_empty` is 1 and `xmit_empty` is 1.
- R2: Select 3 writes the format register. When format bit 7 is 0, select 0 loads the holding byte and select 1 leaves the divisor unchanged. When format bit 7 is 1, select 0 writes divisor bits 7:0 and select 1 writes divisor bits 15:8, and neither write touches the holding byte.
- R3: Format bits 1:0 set the data width: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8.
- R4: The idle line is 1. Each frame begins with one start bit at 0, followed by the data bits least significant first.
- R5: Format bit 3 adds a parity bit after the data bits. Format bits 5:4 choose its value: 0 makes the count of ones in data plus parity odd, 1 makes it even, 2 forces the bit to 1 and 3 forces it to 0.
- R6: When format bit 2 is 0, the stop level (1) lasts 16 ticks. When it is 1, the stop level lasts 32 ticks, or 24 ticks if the data width is 5 bits.
- R7: While format bit 6 is 1, `txd` is 0 from the cycle after the write that set the bit. Clearing the bit returns the line to its normal level one cycle later.
- R8: Every start, data and parity bit lasts 16 ticks, with one tick every divisor clocks. A byte written during a frame starts exactly when that frame's last stop tick ends.
- R9: A holding-byte write drives `hold_empty` to 0 at the next edge. An idle transmitter takes the byte one cycle later, which sets `hold_empty` back to 1. `xmit_empty` is 1 only when the holding byte is empty and no frame is in progress.
- R10: A divisor value of 0 behaves as a divisor of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 data/divisor low, 1 divisor high, 3 format) |
| reg_wdata | input | 8 | Register write data |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding byte is empty |
| xmit_empty | output | 1 | Holding byte and shift engine are both empty |

## Verification
The status outputs change one edge after a write is sampled, and `hold_empty` recovers on the edge after that when the engine is idle. The bench reads both at the falling edges that directly follow those rising edges. The line lags the shift state by one register, and the break mode shows up one cycle after its format write. Frames are therefore checked relative to the observed falling start edge: every bit is sampled at 8 + 16·k tick periods after that edge. The spacing between starts of back-to-back frames is compared with the exact tick count multiplied by the divisor. The first frame after an idle period starts at an arbitrary tick phase, so its spacing to the next frame is not checked when the divisor is greater than 1.

// File: rtl/stx_pkg.sv
package stx_pkg;

  localparam logic [1:0] SEL_LO  = 2'd0;
  localparam logic [1:0] SEL_HI  = 2'd1;
  localparam logic [1:0] SEL_FMT = 2'd3;

  localparam int FMT_DLAB  = 7;
  localparam int FMT_BREAK = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       stop_ext;
    logic       par_en;
    logic [1:0] par_sel;
  } frame_fmt_t;

  function automatic frame_fmt_t decode_fmt(input logic [7:0] c);
    frame_fmt_t f;
    f.len      = c[1:0];
    f.stop_ext = c[2];
    f.par_en   = c[3];
    f.par_sel  = c[5:4];
    return f;
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] len,
                                   input logic [1:0] sel);
    logic [7:0] m;
    m = d & (8'hFF >> (2'd3 - len));
    case (sel)
      2'd0:    return ~^m;
      2'd1:    return ^m;
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/stx_regs.sv
module stx_regs
  import stx_pkg::*;
#(
  parameter int              DIV_W     = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 1,
  parameter logic [7:0]      FMT_RESET = 8'h03
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [7:0]       wdata,
  input  logic             take,
  output logic [7:0]       fmt_ctl,
  output logic [DIV_W-1:0] divisor,
  output logic [7:0]       hold_data,
  output logic             hold_full,
  output logic             div_wr
);

  logic dlab;
  assign dlab   = fmt_ctl[FMT_DLAB];
  assign div_wr = we && dlab && (sel == SEL_LO || sel == SEL_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_ctl   <= FMT_RESET;
      divisor   <= DIV_RESET;
      hold_data <= '0;
      hold_full <= 1'b0;
    end else begin
      if (take) hold_full <= 1'b0;
      if (we) begin
        case (sel)
          SEL_LO: begin
            if (dlab) divisor[7:0] <= wdata;
            else begin
              hold_data <= wdata;
              hold_full <= 1'b1;
            end
          end
          SEL_HI:  if (dlab) divisor[DIV_W-1:8] <= wdata[DIV_W-9:0];
          SEL_FMT: fmt_ctl <= wdata;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/stx_baud.sv
module stx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim = (divisor == '0) ? '0 : divisor - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/stx_shift.sv
module stx_shift
  import stx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       hold_full,
  input  logic [7:0] hold_data,
  input  logic [7:0] fmt_ctl,
  output logic       take,
  output logic       line_q,
  output logic       busy
);

  localparam int TW = $clog2(2 * OVS);
  localparam logic [TW-1:0] LAST_1  = TW'(OVS - 1);
  localparam logic [TW-1:0] LAST_15 = TW'(OVS + OVS / 2 - 1);
  localparam logic [TW-1:0] LAST_2  = TW'(2 * OVS - 1);

  tx_state_e  state;
  logic [TW-1:0] tcnt;
  logic [2:0] bcnt;
  logic [7:0] shreg;
  frame_fmt_t fmt;
  logic       pbit;
  logic [TW-1:0] stop_last;
  logic       level;
  logic       stop_done;
  logic       bit_done;

  always_comb begin
    if (!fmt.stop_ext)      stop_last = LAST_1;
    else if (fmt.len == 0)  stop_last = LAST_15;
    else                    stop_last = LAST_2;
  end

  assign bit_done  = tick && (tcnt == LAST_1);
  assign stop_done = (state == ST_STOP) && tick && (tcnt == stop_last);
  assign take      = hold_full && ((state == ST_IDLE) || stop_done);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    case (state)
      ST_START: level = 1'b0;
      ST_DATA:  level = shreg[0];
      ST_PAR:   level = pbit;
      default:  level = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      tcnt   <= '0;
      bcnt   <= '0;
      shreg  <= '0;
      fmt    <= '0;
      pbit   <= 1'b0;
      line_q <= 1'b1;
    end else begin
      line_q <= fmt_ctl[FMT_BREAK] ? 1'b0 : level;
      if (take) begin
        shreg <= hold_data;
        fmt   <= decode_fmt(fmt_ctl);
        pbit  <= par_bit(hold_data, fmt_ctl[1:0], fmt_ctl[5:4]);
        state <= ST_START;
        tcnt  <= '0;
        bcnt  <= '0;
      end else if (tick) begin
        case (state)
          ST_START: begin
            if (bit_done) begin
              tcnt  <= '0;
              state <= ST_DATA;
            end else tcnt <= tcnt + 1'b1;
          end
          ST_DATA: begin
            if (bit_done) begin
              tcnt  <= '0;
              shreg <= shreg >> 1;
              if (bcnt == 3'(fmt.len) + 3'd4)
                state <= fmt.par_en ? ST_PAR : ST_STOP;
              else
                bcnt <= bcnt + 1'b1;
            end else tcnt <= tcnt + 1'b1;
          end
          ST_PAR: begin
            if (bit_done) begin
              tcnt  <= '0;
              state <= ST_STOP;
            end else tcnt <= tcnt + 1'b1;
          end
          ST_STOP: begin
            if (tcnt == stop_last) begin
              tcnt  <= '0;
              state <= ST_IDLE;
            end else tcnt <= tcnt + 1'b1;
          end
          default: tcnt <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer #(
  parameter int              DIV_W     = 16,
  parameter int              OVS       = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 1,
  parameter logic [7:0]      FMT_RESET = 8'h03
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic       txd,
  output logic       hold_empty,
  output logic       xmit_empty
);

  logic [7:0]       fmt_ctl;
  logic [DIV_W-1:0] divisor;
  logic [7:0]       hold_data;
  logic             hold_full;
  logic             div_wr;
  logic             take;
  logic             tick;
  logic             shift_busy;

  stx_regs #(
    .DIV_W(DIV_W), .DIV_RESET(DIV_RESET), .FMT_RESET(FMT_RESET)
  ) i_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .take(take), .fmt_ctl(fmt_ctl), .divisor(divisor),
    .hold_data(hold_data), .hold_full(hold_full), .div_wr(div_wr)
  );

  stx_baud #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rst(rst), .restart(div_wr), .divisor(divisor), .tick(tick)
  );

  stx_shift #(.OVS(OVS)) i_shift (
    .clk(clk), .rst(rst), .tick(tick), .hold_full(hold_full),
    .hold_data(hold_data), .fmt_ctl(fmt_ctl), .take(take),
    .line_q(txd), .busy(shift_busy)
  );

  assign hold_empty = !hold_full;
  assign xmit_empty = !hold_full && !shift_busy;

endmodule

// File: rtl/stx_checker.sv
module stx_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic [1:0]       reg_sel,
  input logic             txd,
  input logic             hold_empty,
  input logic             xmit_empty,
  input logic [7:0]       fmt_ctl,
  input logic [DIV_W-1:0] divisor,
  input logic             shift_busy
);

  a_r7_break_low: assert property (@(posedge clk) disable iff (rst)
    $past(fmt_ctl[6]) |-> !txd);

  a_r9_xmit_needs_hold: assert property (@(posedge clk) disable iff (rst)
    xmit_empty |-> hold_empty);

  a_r4_idle_high: assert property (@(posedge clk) disable iff (rst)
    (xmit_empty && $past(xmit_empty) && !$past(fmt_ctl[6])) |-> txd);

  a_r4_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(shift_busy) |=> !txd);

  a_r2_hold_load: assert property (@(posedge clk) disable iff (rst)
    $past(reg_we && reg_sel == 2'd0 && !fmt_ctl[7]) |-> !hold_empty);

  a_r2_div_guard: assert property (@(posedge clk) disable iff (rst)
    $past(reg_we && reg_sel == 2'd1 && !fmt_ctl[7]) |-> $stable(divisor));

endmodule

bind serial_tx_framer stx_checker #(.DIV_W(DIV_W)) i_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .txd(txd),
  .hold_empty(hold_empty), .xmit_empty(xmit_empty), .fmt_ctl(fmt_ctl),
  .divisor(divisor), .shift_busy(shift_busy)
);

// File: tb/test_serial_tx_framer.sv
module test_serial_tx_framer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  wire        txd, hold_empty, xmit_empty;

  serial_tx_framer i_serial_tx_framer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .txd(txd), .hold_empty(hold_empty),
    .xmit_empty(xmit_empty)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [7:0] data;
    int nbits;
    bit par_en;
    logic par_val;
    int gap;
    int div;
  } item_t;

  item_t sbq[$];
  int vec = 0, bad = 0, cyc = 0;
  bit done = 0, mon_en = 1, mon_busy = 0;
  logic [7:0] cur_fmt = 8'h03;
  int cur_div = 1;

  always @(posedge clk) cyc++;

  task automatic chk(string req, string what, int act, int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (s == 2'd3) cur_fmt = d;
  endtask

  task automatic set_div(int d);
    wr(2'd3, cur_fmt | 8'h80);
    wr(2'd0, d[7:0]);
    wr(2'd1, d[15:8]);
    wr(2'd3, cur_fmt & 8'h7F);
    cur_div = (d == 0) ? 1 : d;
  endtask

  // driver: pushes the expected frame, then writes the holding byte
  task automatic send(logic [7:0] d, bit chk_gap, bit chk_stat);
    item_t it;
    int ones, stp;
    while (!hold_empty) @(negedge clk);
    it.data   = d;
    it.nbits  = int'(cur_fmt[1:0]) + 5;
    it.par_en = cur_fmt[3];
    ones = $countones(d & 8'((1 << it.nbits) - 1));
    case (cur_fmt[5:4])
      2'd0: it.par_val = (ones % 2 == 0);
      2'd1: it.par_val = (ones % 2 == 1);
      2'd2: it.par_val = 1'b1;
      default: it.par_val = 1'b0;
    endcase
    stp = !cur_fmt[2] ? 16 : (cur_fmt[1:0] == 2'd0 ? 24 : 32);
    it.gap = chk_gap ? ((1 + it.nbits + int'(it.par_en)) * 16 + stp) * cur_div : 0;
    it.div = cur_div;
    sbq.push_back(it);
    wr(2'd0, d);
    if (chk_stat) begin
      chk("R9", "hold_empty after write", hold_empty, 0);
      chk("R9", "xmit_empty after write", xmit_empty, 0);
      @(negedge clk);
      chk("R9", "hold_empty after take", hold_empty, 1);
      chk("R9", "xmit_empty while sending", xmit_empty, 0);
    end
  endtask

  task automatic drain();
    while (!xmit_empty || sbq.size() != 0 || mon_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops expected frames at each start edge and compares
  initial begin
    logic prev;
    logic [7:0] got;
    item_t it;
    int c0, last_c0;
    prev = 1'b1; last_c0 = 0;
    forever begin
      @(negedge clk);
      if (mon_en && prev && !txd) begin
        c0 = cyc;
        mon_busy = 1;
        if (sbq.size() == 0) chk("R4", "unexpected frame start", 1, 0);
        else begin
          it = sbq.pop_front();
          if (it.gap != 0) chk("R8", "start-to-start cycles", c0 - last_c0, it.gap);
          repeat (8 * it.div) @(negedge clk);
          chk("R4", "start bit level", int'(txd), 0);
          got = 8'd0;
          for (int k = 0; k < it.nbits; k++) begin
            repeat (16 * it.div) @(negedge clk);
            got[k] = txd;
          end
          chk("R3", "data bits", int'(got), int'(it.data & 8'((1 << it.nbits) - 1)));
          if (it.par_en) begin
            repeat (16 * it.div) @(negedge clk);
            chk("R5", "parity bit", int'(txd), int'(it.par_val));
          end
          repeat (16 * it.div) @(negedge clk);
          chk("R6", "stop level", int'(txd), 1);
        end
        last_c0 = c0;
        mon_busy = 0;
      end
      prev = txd;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "txd in reset", int'(txd), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "txd after reset", int'(txd), 1);
    chk("R1", "hold_empty after reset", int'(hold_empty), 1);
    chk("R1", "xmit_empty after reset", int'(xmit_empty), 1);

    // R2: divisor-low write under the access bit does not fill the holding byte
    wr(2'd3, 8'h83);
    wr(2'd0, 8'd1);
    chk("R2", "hold_empty after divisor write", int'(hold_empty), 1);
    chk("R2", "xmit_empty after divisor write", int'(xmit_empty), 1);
    wr(2'd1, 8'd0);
    wr(2'd3, 8'h03);
    cur_div = 1;

    send(8'hA5, 0, 1);
    send(8'h3C, 1, 0);
    drain();
    chk("R9", "xmit_empty when done", int'(xmit_empty), 1);

    wr(2'd3, 8'h00); send(8'h1F, 0, 0); send(8'h15, 1, 0); drain();
    wr(2'd3, 8'h1D); send(8'h2A, 0, 0); send(8'h15, 1, 0); drain();
    wr(2'd3, 8'h0A); send(8'h55, 0, 0); send(8'h7F, 1, 0); drain();
    wr(2'd3, 8'h2B); send(8'h00, 0, 0); send(8'h81, 1, 0); drain();
    wr(2'd3, 8'h3B); send(8'hFF, 0, 0); send(8'h7E, 1, 0); drain();
    wr(2'd3, 8'h04); send(8'h11, 0, 0); send(8'h0E, 1, 0); drain();
    wr(2'd3, 8'h07); send(8'hC3, 0, 0); send(8'h5A, 1, 0); drain();
    wr(2'd3, 8'h0E); send(8'h64, 0, 0); send(8'h13, 1, 0); drain();

    // R8 with divisor 3; the select-1 write without the access bit must be
    // dropped (R2), otherwise the bit timing below breaks
    set_div(3);
    wr(2'd1, 8'h55);
    wr(2'd3, 8'h0B);
    send(8'h96, 0, 0); send(8'h69, 0, 0); send(8'hF0, 1, 0); drain();

    // R10: divisor 0 runs as divisor 1
    set_div(0);
    send(8'h3A, 0, 0); send(8'hC5, 1, 0); drain();

    // R7: break holds the line low
    mon_en = 0;
    wr(2'd3, cur_fmt | 8'h40);
    @(negedge clk);
    chk("R7", "txd under break", int'(txd), 0);
    repeat (20) @(negedge clk);
    chk("R7", "txd still under break", int'(txd), 0);
    wr(2'd3, cur_fmt & 8'hBF);
    @(negedge clk);
    chk("R7", "txd after break cleared", int'(txd), 1);
    repeat (4) @(negedge clk);
    mon_en = 1;

    send(8'h42, 0, 0); drain();
    chk("R4", "scoreboard empty", sbq.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule